// File: doc/BRIEF.md
# Handshake Sequence Watchdog Monitor

A synthesizable runtime checker that observes three single-bit signals (a start request, a grant and a completion) and enforces both bounded deadlines and event order. A rising edge of the start signal arms the monitor. The grant must then appear within a parameterized window. After the first grant, the completion must appear within a second parameterized window. A missing grant, a missing completion, or a completion that arrives before any grant ends the check with a one-cycle error pulse and a 2-bit cause code. A completion that arrives in time ends the check with a one-cycle pass pulse.

The monitor never drives the observed signals. It is placed beside a handshake in silicon or in simulation so that a stalled or reordered transaction is reported at a known cycle and does not go unnoticed. A busy flag shows that a check is in progress. A separate overlap pulse reports any start edge that arrives during a check, and such an edge is otherwise ignored.

All outputs are registered. Each one changes on the clock edge where the deciding input is sampled. Cycle numbers below count sampled edges, with the arming edge as cycle 0.

Top module: `hs_seq_monitor`

## Requirements
- R1: While rst_n is low and after its release, busy_o, pass_o, err_o, overlap_o are 0 and err_cause_o is 00 until a start edge is sampled.
- R2: Only a sampled 0-to-1 transition of start_i arms the monitor (busy_o rises after that edge); a start_i held high after a check ends does not re-arm it.
- R3: A grant sampled in cycles 1..GNT_WIN moves the check to the completion phase; a grant sampled in cycle 0 is not used; busy_o stays 1 while the check is open.
- R4: If no grant is sampled by cycle GNT_WIN, err_o pulses after that edge with err_cause_o = 01 and busy_o drops.
- R5: A done sampled 1..DONE_WIN cycles after the accepted grant gives a one-cycle pass_o, and busy_o drops; a done in the same cycle as the grant is ignored.
- R6: If no done is sampled within DONE_WIN cycles after the grant, err_o pulses after cycle grant+DONE_WIN with err_cause_o = 10.
- R7: A done sampled in cycles 1..GNT_WIN before any grant ends the check at once with err_o and err_cause_o = 11.
- R8: Only the first grant after arming anchors the completion window; later or held grants do not move it.
- R9: A start edge sampled while busy_o is 1 raises overlap_o for one cycle and changes neither the phase nor the deadlines.
- R10: pass_o and err_o are single-cycle pulses that never coincide with each other or with busy_o; err_cause_o is 00 whenever err_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Observed start request; its rising edge arms a check |
| grant_i | input | 1 | Observed grant |
| done_i | input | 1 | Observed completion |
| busy_o | output | 1 | A check is in progress |
| pass_o | output | 1 | One-cycle pulse: completion seen in time and in order |
| err_o | output | 1 | One-cycle pulse: a check failed |
| err_cause_o | output | 2 | 01 grant timeout, 10 done timeout, 11 order violation, 00 none |
| overlap_o | output | 1 | One-cycle pulse: start edge seen during a check and ignored |

## Verification
A wrong phase or a wrong count shows at the ports as a verdict in the wrong cycle, with the wrong cause, or with busy_o held or dropped early. A deadline counter that is off by one moves the timeout pulse by exactly one cycle. A phase that is missed swaps the cause between order violation and done timeout. The sweep places every grant and done offset around both window edges, so each of these faults appears at the first cycle where the expected verdict differs.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_GNT  = 2'd1,
        ST_WAIT_DONE = 2'd2
    } mon_state_e;

    localparam logic [1:0] CAUSE_NONE    = 2'b00;
    localparam logic [1:0] CAUSE_GNT_TO  = 2'b01;
    localparam logic [1:0] CAUSE_DONE_TO = 2'b10;
    localparam logic [1:0] CAUSE_ORDER   = 2'b11;

    typedef struct packed {
        mon_state_e  state;
        logic        pass;
        logic        err;
        logic [1:0]  cause;
        logic        overlap;
    } mon_regs_t;

endpackage

// File: rtl/hs_rise_det.sv
module hs_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/hs_win_ctr.sv
module hs_win_ctr #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic last_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = W'(1);
        else if (run_i && cnt_q < LIM)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LIM);
endmodule

// File: rtl/hs_seq_monitor.sv
module hs_seq_monitor
    import hs_mon_pkg::*;
#(
    parameter int GNT_WIN  = 10,
    parameter int DONE_WIN = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       grant_i,
    input  logic       done_i,
    output logic       busy_o,
    output logic       pass_o,
    output logic       err_o,
    output logic [1:0] err_cause_o,
    output logic       overlap_o
);
    mon_regs_t r_d, r_q;
    logic      start_rise;
    logic      gnt_last, done_last;
    logic      gnt_load, gnt_run, done_load, done_run;

    hs_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (start_i),
        .rise_o (start_rise)
    );

    assign gnt_load  = (r_q.state == ST_IDLE) && start_rise;
    assign gnt_run   = (r_q.state == ST_WAIT_GNT);
    assign done_load = (r_q.state == ST_WAIT_GNT) && grant_i;
    assign done_run  = (r_q.state == ST_WAIT_DONE);

    hs_win_ctr #(.LIMIT(GNT_WIN)) u_gnt_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gnt_load),
        .run_i  (gnt_run),
        .last_o (gnt_last)
    );

    hs_win_ctr #(.LIMIT(DONE_WIN)) u_done_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (done_load),
        .run_i  (done_run),
        .last_o (done_last)
    );

    always_comb begin
        r_d         = r_q;
        r_d.pass    = 1'b0;
        r_d.err     = 1'b0;
        r_d.cause   = CAUSE_NONE;
        r_d.overlap = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_rise) r_d.state = ST_WAIT_GNT;
            end
            ST_WAIT_GNT: begin
                r_d.overlap = start_rise;
                if (grant_i) begin
                    r_d.state = ST_WAIT_DONE;
                end else if (done_i) begin
                    r_d.state = ST_IDLE;
                    r_d.err   = 1'b1;
                    r_d.cause = CAUSE_ORDER;
                end else if (gnt_last) begin
                    r_d.state = ST_IDLE;
                    r_d.err   = 1'b1;
                    r_d.cause = CAUSE_GNT_TO;
                end
            end
            ST_WAIT_DONE: begin
                r_d.overlap = start_rise;
                if (done_i) begin
                    r_d.state = ST_IDLE;
                    r_d.pass  = 1'b1;
                end else if (done_last) begin
                    r_d.state = ST_IDLE;
                    r_d.err   = 1'b1;
                    r_d.cause = CAUSE_DONE_TO;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.pass    <= 1'b0;
            r_q.err     <= 1'b0;
            r_q.cause   <= CAUSE_NONE;
            r_q.overlap <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.state != ST_IDLE);
    assign pass_o      = r_q.pass;
    assign err_o       = r_q.err;
    assign err_cause_o = r_q.cause;
    assign overlap_o   = r_q.overlap;
endmodule

// File: rtl/hs_seq_monitor_chk.sv
module hs_seq_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       grant_i,
    input logic       done_i,
    input logic       busy_o,
    input logic       pass_o,
    input logic       err_o,
    input logic [1:0] err_cause_o,
    input logic       overlap_o
);
    // R2
    busy_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R4
    gnt_to_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_cause_o == 2'b01) |-> ($past(busy_o) && !$past(grant_i) && !$past(done_i)));

    // R5
    pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> ($past(done_i) && $past(busy_o)));

    // R7
    order_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_cause_o == 2'b11) |-> ($past(done_i) && !$past(grant_i)));

    // R9
    overlap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_o |-> ($past(busy_o) && $past(start_i) && busy_o == $past(busy_o) || pass_o || err_o));

    // R10
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pass_o, err_o, busy_o}) <= 1);

    // R10
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o == (err_cause_o != 2'b00)));

    // R10
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || err_o) |=> !(pass_o || err_o));
endmodule

bind hs_seq_monitor hs_seq_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .grant_i     (grant_i),
    .done_i      (done_i),
    .busy_o      (busy_o),
    .pass_o      (pass_o),
    .err_o       (err_o),
    .err_cause_o (err_cause_o),
    .overlap_o   (overlap_o)
);

// File: tb/hs_seq_monitor_tb.sv
`timescale 1ns/1ps
module hs_seq_monitor_tb;
    localparam int GW = 4;
    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, grant_i = 1'b0, done_i = 1'b0;
    logic busy_o, pass_o, err_o, overlap_o;
    logic [1:0] err_cause_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hs_seq_monitor #(.GNT_WIN(GW), .DONE_WIN(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .grant_i(grant_i),
        .done_i(done_i), .busy_o(busy_o), .pass_o(pass_o), .err_o(err_o),
        .err_cause_o(err_cause_o), .overlap_o(overlap_o)
    );

    task automatic step(input logic s, input logic g, input logic d);
        start_i = s; grant_i = g; done_i = d;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic b, input logic p,
                              input logic e, input logic [1:0] c, input logic o);
        checks++;
        if ({busy_o, pass_o, err_o, err_cause_o, overlap_o} !== {b, p, e, c, o}) begin
            fails++;
            $display("FAIL %s t=%0t actual busy=%b pass=%b err=%b cause=%b ovl=%b expected busy=%b pass=%b err=%b cause=%b ovl=%b",
                     tag, $time, busy_o, pass_o, err_o, err_cause_o, overlap_o, b, p, e, c, o);
        end
    endtask

    // kind: 0 pass, 1 grant timeout, 2 done timeout, 3 order violation
    task automatic predict(input int g, input int d, output int endk, output int kind);
        if (g >= 1 && g <= GW) begin
            if (d >= 1 && d < g)               begin endk = d;      kind = 3; end
            else if (d > g && d - g <= DW)     begin endk = d;      kind = 0; end
            else                               begin endk = g + DW; kind = 2; end
        end else begin
            if (d >= 1 && d <= GW)             begin endk = d;      kind = 3; end
            else                               begin endk = GW;     kind = 1; end
        end
    endtask

    task automatic run_case(input int g, input int d, input bit hold);
        int endk, kind;
        string tag;
        logic [1:0] cause;
        predict(g, d, endk, kind);
        case (kind)
            0: begin tag = hold ? "R5/R8" : "R5"; cause = 2'b00; end
            1: begin tag = "R4";                  cause = 2'b01; end
            2: begin tag = hold ? "R6/R8" : "R6"; cause = 2'b10; end
            default: begin tag = "R7";            cause = 2'b11; end
        endcase
        step(1'b0, 1'b0, 1'b0);
        for (int k = 0; k <= endk; k++) begin
            logic gv;
            gv = (k == g) || (hold && g >= 1 && k >= g);
            step(k == 0, gv, k == d);
            if (k < endk) expect_out("R3", 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
            else          expect_out(tag, 1'b0, kind == 0, kind != 0, cause, 1'b0);
        end
        step(1'b0, 1'b0, 1'b0);
        expect_out("R10", 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        start_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1", 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1);
        expect_out("R1", 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);

        for (int h = 0; h < 2; h++)
            for (int g = -1; g <= GW + 2; g++)
                for (int d = -1; d <= GW + DW + 2; d++)
                    run_case(g, d, h[0]);

        // R9: second start edge during the check is ignored and flagged
        step(1'b1, 1'b0, 1'b0);
        expect_out("R2", 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        expect_out("R9", 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        // start stays high until the grant deadline at cycle GW
        for (int k = 3; k <= GW; k++) begin
            step(1'b1, 1'b0, 1'b0);
            if (k < GW) expect_out("R9", 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
            else        expect_out("R9", 1'b0, 1'b0, 1'b1, 2'b01, 1'b0);
        end
        // R2: a held level does not re-arm
        for (int k = 0; k < GW + 2; k++) begin
            step(1'b1, 1'b0, 1'b0);
            expect_out("R2", 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        end
        // R2: new edge after release arms again; grant at 1, done at 2 passes
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        expect_out("R2", 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        expect_out("R3", 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        expect_out("R5", 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        expect_out("R10", 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);

        // R1: reset in mid-check clears everything
        step(1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        step(1'b1, 1'b0, 1'b0);
        expect_out("R1", 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule